// File: doc/BRIEF.md
# I2C Register Access Target

This block lets an external I2C master read and write a bank of byte-wide registers. It oversamples the SCL and SDA lines with the system clock, recognises start, repeated start and stop conditions, and answers to one fixed 7-bit device address. After the address, the master sends a one-byte register pointer (subaddress) and then data bytes. In the write direction each data byte is stored at the pointer, and the pointer then steps up by one. For reads, the master first writes the pointer, then issues a repeated start with the read bit set, and the block returns register contents one byte after another.

The register storage sits outside the block. It is reached through a plain parallel port: an address, write data, a one-cycle write strobe and combinational read data. SDA is driven through an open-drain enable that only ever pulls the line low. Valid pointers run from 0 to the parameter `MAX_SUB`.

The block does not stretch the clock and has no 10-bit or general-call addressing. A write that runs past the top register is refused: the byte is not acknowledged and the block goes idle. A read that runs past the top keeps returning the top register until the master stops acknowledging.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is active and right after it, `sda_oe` is 0 and `reg_we` is 0.
- R2: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. A start at any point restarts address reception. A stop at any point returns the block to idle with `sda_oe` at 0.
- R3: The first byte after a start is taken MSB first: bits 7..1 are the device address and bit 0 is the direction (0 = write, 1 = read). If the address equals `DEV_ADDR`, the block pulls SDA low during the ninth SCL pulse. On a mismatch, it leaves SDA released and ignores the bus until the next start.
- R4: In a write, the byte after the address is the pointer. Each following data byte is acknowledged and produces exactly one `reg_we` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte. The pointer then increments by one.
- R5: A pointer byte above `MAX_SUB` is not acknowledged. The block goes idle and no write happens until the next start.
- R6: A data byte that would land at a pointer above `MAX_SUB` is not stored and not acknowledged. The block goes idle, so later bytes in the same transfer are ignored.
- R7: In a read, the block sends the register at the pointer MSB first. A master acknowledge (SDA low on the ninth pulse) advances the pointer and starts the next byte. A master no-acknowledge ends the transfer.
- R8: A read that reaches pointer `MAX_SUB` keeps returning that register for every further acknowledged byte.
- R9: `sda_oe` changes only while SCL is low. Its only effect is to pull SDA low.
- R10: The pointer written in one transfer survives a repeated start, so the next read begins at that pointer.
- R11: A byte cut short by a stop or a start produces no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | SUB_W | Register pointer presented to the storage |
| reg_wdata | output | 8 | Byte to be written |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
A bus condition and byte-level progress can fall in the same cycle: a stop or start can arrive while the engine is part-way through shifting a pointer or data byte, and the condition must take priority. The bench provokes this by issuing a stop after four data bits, and by issuing a start in the middle of a pointer byte and then completing a fresh transfer. The scoreboard judges the outcome. It reports any write strobe that the driver did not queue, and later read-backs confirm that the register kept its old value. The new transfer after the mid-byte start must be acknowledged and stored normally.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_SUB,
    ST_ACK_SUB,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_MACK
  } tgt_state_e;

  // address byte carries the device address in bits 7..1
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] dev);
    return frame[7:1] == dev;
  endfunction

  function automatic logic within_top(input logic [15:0] v, input logic [15:0] top);
    return v <= top;
  endfunction

  // read pointer advance, pinned at the top register
  function automatic logic [15:0] rd_advance(input logic [15:0] v, input logic [15:0] top);
    return (v >= top) ? top : v + 16'd1;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh;
  logic [STAGES-1:0] sda_sh;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h3A,
  parameter int unsigned SUB_W    = 8,
  parameter int unsigned MAX_SUB  = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic [SUB_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);

  localparam int unsigned PTR_W = SUB_W + 1;
  localparam logic [15:0] TOP16 = 16'(MAX_SUB);

  tgt_state_e       state;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [PTR_W-1:0] ptr;
  logic             rw_q;
  logic             mack_q;
  logic             oe_q;
  logic             we_q;
  logic [7:0]       wdata_q;

  // named internal events
  logic             byte_done;
  logic             dev_hit;
  logic             sub_ok;
  logic             ptr_ok;
  logic [PTR_W-1:0] ptr_rd_next;
  logic             rx_phase;

  assign byte_done   = (bit_cnt == 4'd8);
  assign dev_hit     = addr_hit(shreg, DEV_ADDR);
  assign sub_ok      = within_top(16'(shreg), TOP16);
  assign ptr_ok      = within_top(16'(ptr), TOP16);
  assign ptr_rd_next = PTR_W'(rd_advance(16'(ptr), TOP16));
  assign rx_phase    = (state == ST_DEV) || (state == ST_SUB) || (state == ST_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= 4'd0;
      shreg   <= 8'd0;
      ptr     <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= 8'd0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        state   <= ST_DEV;
        bit_cnt <= 4'd0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else if (rx_phase) begin
        if (scl_rise && !byte_done) begin
          shreg   <= {shreg[6:0], sda_lvl};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (scl_fall && byte_done) begin
          bit_cnt <= 4'd0;
          if (state == ST_DEV) begin
            if (dev_hit) begin
              oe_q  <= 1'b1;
              rw_q  <= shreg[0];
              state <= ST_ACK_DEV;
            end else begin
              state <= ST_IDLE;
            end
          end else if (state == ST_SUB) begin
            if (sub_ok) begin
              oe_q  <= 1'b1;
              ptr   <= PTR_W'(shreg);
              state <= ST_ACK_SUB;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            if (ptr_ok) begin
              oe_q    <= 1'b1;
              we_q    <= 1'b1;
              wdata_q <= shreg;
              state   <= ST_ACK_WR;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
      end else begin
        case (state)
          ST_ACK_DEV: if (scl_fall) begin
            bit_cnt <= 4'd0;
            if (rw_q) begin
              shreg <= reg_rdata;
              oe_q  <= ~reg_rdata[7];
              state <= ST_RD;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_SUB;
            end
          end
          ST_ACK_SUB: if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_WR;
          end
          ST_ACK_WR: if (scl_fall) begin
            oe_q  <= 1'b0;
            ptr   <= ptr + PTR_W'(1);
            state <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              oe_q    <= 1'b0;
              bit_cnt <= 4'd0;
              state   <= ST_MACK;
            end else begin
              shreg   <= {shreg[6:0], 1'b0};
              oe_q    <= ~shreg[6];
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
              if (!sda_lvl) ptr <= ptr_rd_next;
            end else if (scl_fall) begin
              if (mack_q) begin
                shreg   <= reg_rdata;
                oe_q    <= ~reg_rdata[7];
                bit_cnt <= 4'd0;
                state   <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_addr  = ptr_ok ? ptr[SUB_W-1:0] : SUB_W'(MAX_SUB);

  AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (state == ST_ACK_WR && sda_oe)); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (state == ST_IDLE && !sda_oe)); // R2
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_DEV && bit_cnt == 4'd0)); // R2
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl); // R9

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0]  DEV_ADDR = 7'h3A,
  parameter int unsigned SUB_W    = 8,
  parameter int unsigned MAX_SUB  = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [SUB_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);

  logic scl_lvl;
  logic sda_lvl;
  logic scl_rise;
  logic scl_fall;
  logic start_det;
  logic stop_det;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_engine #(
    .DEV_ADDR (DEV_ADDR),
    .SUB_W    (SUB_W),
    .MAX_SUB  (MAX_SUB)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

endmodule

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;

  localparam int   CLK_P = 10;
  localparam int   QTR   = 10;
  localparam logic [6:0] DEV = 7'h3A;
  localparam int   TOP   = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  wire        sda_bus = sda_m & ~sda_oe;

  int nchk = 0;
  int nfail = 0;
  int oe_viol = 0;
  bit done = 1'b0;

  logic [7:0]  mem     [0:15];
  logic [7:0]  exp_mem [0:15];
  logic [15:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV), .SUB_W(8), .MAX_SUB(TOP)) u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  // register storage outside the block
  assign reg_rdata = mem[reg_addr[3:0]];
  always @(posedge clk) if (reg_we) mem[reg_addr[3:0]] <= reg_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the queued expectation
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        nchk++;
        nfail++;
        $display("FAIL R6/R11 unexpected write act=%0h:%0h exp=none", reg_addr, reg_wdata);
      end else begin
        logic [15:0] it;
        it = exp_q.pop_front();
        chk("R4 write strobe addr/data", {reg_addr, reg_wdata}, it);
      end
    end
  end

  // R9 port watch: enable may only move while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe != oe_prev) && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  task automatic q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; q();
    scl_m = 1'b1; q(); q();
    scl_m = 1'b0; q();
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    b = sda_bus; q();
    scl_m = 1'b0; q();
  endtask

  task automatic wb(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(b);
    ack = ~b;
  endtask

  task automatic rb(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  // driver: a stored byte is queued before it is sent
  task automatic wb_store(input int a, input logic [7:0] d, input string tag);
    logic ack;
    exp_q.push_back({8'(a), d});
    exp_mem[a] = d;
    wb(d, ack);
    chk(tag, ack, 1'b1);
  endtask

  task automatic open_write(input int sub, input string tag);
    logic ack;
    bus_start();
    wb({DEV, 1'b0}, ack); chk({tag, " dev ack"}, ack, 1'b1);
    wb(8'(sub), ack);     chk({tag, " sub ack"}, ack, 1'b1);
  endtask

  task automatic read_from(input int sub, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    int p;
    open_write(sub, tag);
    bus_start();
    wb({DEV, 1'b1}, ack); chk({tag, " read dev ack"}, ack, 1'b1);
    p = sub;
    for (int i = 0; i < n; i++) begin
      rb(d, i != n - 1);
      chk(tag, d, exp_mem[p]);
      if (p < TOP) p++;
    end
    bus_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nchk++;
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic ack;
    for (int i = 0; i < 16; i++) begin
      mem[i]     = 8'(8'h96 ^ (i * 8'h13));
      exp_mem[i] = 8'(8'h96 ^ (i * 8'h13));
    end
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 1'b0);
    chk("R1 we in reset", reg_we, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", sda_oe, 1'b0);

    // R3 R4 single write
    open_write(3, "R3 R4 single");
    wb_store(3, 8'hA5, "R4 data ack");
    bus_stop();

    // R4 auto-increment write
    open_write(5, "R4 burst");
    wb_store(5, 8'h11, "R4 burst data 5");
    wb_store(6, 8'h22, "R4 burst data 6");
    wb_store(7, 8'h33, "R4 burst data 7");
    bus_stop();

    // R7 R10 read back through repeated start
    read_from(5, 3, "R7 R10 burst read");
    chk("R2 oe released after stop", sda_oe, 1'b0);
    read_from(3, 1, "R7 single read");
    read_from(0, 2, "R7 read from zero");

    // R3 address mismatch: no ack, rest ignored
    bus_start();
    wb({DEV ^ 7'h01, 1'b0}, ack); chk("R3 mismatch no ack", ack, 1'b0);
    wb(8'd2, ack);                chk("R3 ignored after mismatch", ack, 1'b0);
    wb(8'h5A, ack);               chk("R3 ignored data", ack, 1'b0);
    bus_stop();

    // R5 invalid pointer
    bus_start();
    wb({DEV, 1'b0}, ack);  chk("R5 dev ack", ack, 1'b1);
    wb(8'(TOP + 1), ack);  chk("R5 pointer above top nack", ack, 1'b0);
    wb(8'h77, ack);        chk("R5 data after bad pointer", ack, 1'b0);
    bus_stop();
    bus_start();
    wb({DEV, 1'b0}, ack);  chk("R5 dev ack", ack, 1'b1);
    wb(8'hFF, ack);        chk("R5 pointer FF nack", ack, 1'b0);
    bus_stop();

    // R6 write past top
    open_write(TOP - 1, "R6");
    wb_store(TOP - 1, 8'hC1, "R6 below top ack");
    wb_store(TOP,     8'hC2, "R6 top ack");
    wb(8'hC3, ack); chk("R6 past top nack", ack, 1'b0);
    wb(8'hC4, ack); chk("R6 idle after nack", ack, 1'b0);
    bus_stop();
    read_from(TOP, 1, "R6 top kept value");

    // R8 read past top repeats the top register
    read_from(TOP - 1, 5, "R8 read past top");

    // R11 stop in the middle of a data byte
    open_write(2, "R11 stop abort");
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    read_from(2, 1, "R11 unchanged after stop");

    // R2 R11 start in the middle of the pointer byte restarts addressing
    bus_start();
    wb({DEV, 1'b0}, ack); chk("R2 dev ack", ack, 1'b1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    wb({DEV, 1'b0}, ack); chk("R2 dev ack after mid-byte start", ack, 1'b1);
    wb(8'd2, ack);        chk("R2 pointer ack after restart", ack, 1'b1);
    wb_store(2, 8'h5E, "R2 data after restart");
    bus_stop();
    read_from(2, 1, "R11 R2 readback");

    repeat (20) @(negedge clk);
    chk("R4 all queued writes seen", exp_q.size(), 0);
    chk("R9 oe moved only with SCL low", oe_viol, 0);
    chk("R9 oe idle at end", sda_oe, 1'b0);
    finish_run();
  end

endmodule